// File: doc/BRIEF.md
# SGRAM Command Decoder and Sequencing Checker

This block watches the command pins of a two-bank synchronous graphics DRAM. On every rising clock edge it samples chip select, the three strobe pins, the graphics-mode pin, a bank-select address bit, an auto-precharge/all-banks address bit, the burst-length setting and the byte-mask pin. It names the command that was issued and reports whether that command is legal given what each bank is doing. When the graphics-mode pin is high, a write becomes a block write and a mode-register load becomes a special mode-register load. A row activate records, for its bank, whether write-per-bit masking applies to later writes.

The checker keeps the following state. Each bank is idle, open or precharging. A single burst tracker covers the shared data bus. A short pipeline turns the sampled byte mask into a write-data mask and a read output-disable strobe. A violation raises a one-cycle error pulse, and the offending command leaves all tracked state unchanged. A monitor or a memory controller's self-check logic can use the block to catch sequencing faults next to the memory.

Top module: `sgram_cmd_check`

## Requirements
- R1: With the graphics-mode pin low, the block decodes commands as follows. Chip select high, or strobes RAS/CAS/WE = 1/1/1, is NOP (bit 0). 0/1/1 is ACTIVATE (bit 1). 1/0/1 is READ (bit 2). 1/0/0 is WRITE (bit 3). 0/1/0 is PRECHARGE (bit 5). 0/0/1 is REFRESH (bit 6). 0/0/0 is MODE SET (bit 7). 1/1/0 is BURST STOP (bit 9). The command appears on the one-hot `cmdHot` in the cycle after the edge that sampled it.
- R2: With the graphics-mode pin high, WRITE decodes as BLOCK WRITE (bit 4) and MODE SET decodes as SPECIAL MODE SET (bit 8). Every other command decodes as it does with the pin low.
- R3: `bankSel` low selects bank A (index 0) and high selects bank B (index 1). The selected bank is reported on `cmdBank`. An ACTIVATE is legal only when the target bank is idle, and it opens that bank.
- R4: A legal ACTIVATE sets the bank's write-per-bit flag to the graphics-mode pin and the bank holds that value until its next activate. A legal WRITE or BLOCK WRITE raises `wrMasked` exactly when the target bank's flag is set.
- R5: A PRECHARGE moves the selected open bank to precharging. With `apAll` high it ignores `bankSel` and acts on both banks. A precharging bank becomes idle TRP edges after the precharge edge. An ACTIVATE to a bank that is open or precharging is a violation.
- R6: A READ, WRITE or BLOCK WRITE to a bank that is not open is a violation.
- R7: Burst codes 0, 1, 2 and 3 give lengths 1, 2, 4 and 8. Code 7 is full page (PAGE_LEN). Other codes give length 1, and a block write is always length 1. When a READ or WRITE is issued with `apAll` high, any READ, WRITE or BLOCK WRITE during the next burst-length edges is a violation. On the last of those edges the bank starts precharging.
- R8: A BURST STOP is legal only when the burst code is 7. A legal stop ends the running burst and cancels its auto-precharge.
- R9: A REFRESH is legal only when both banks are idle.
- R10: A violation raises `errPulse` for one cycle, and the offending command changes no bank state, write-per-bit flag or burst state.
- R11: `dinMask` shows the byte-mask value sampled at the same edge as the command (write latency 0). `doutHiZ` shows that value two edges later (read latency 2).
- R12: After reset, `cmdHot` shows NOP, both banks are idle with write-per-bit clear, and `errPulse`, `wrMasked`, `dinMask` and `doutHiZ` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dsf | input | 1 | Graphics-mode pin selecting the command variant |
| bankSel | input | 1 | Bank-select address bit |
| apAll | input | 1 | Auto-precharge on access, all banks on precharge |
| burstCode | input | 3 | Burst-length setting |
| dqm | input | 1 | Byte-mask pin |
| cmdHot | output | 10 | One-hot decoded command |
| cmdBank | output | 1 | Bank of the decoded command |
| errPulse | output | 1 | One-cycle sequencing violation |
| wrMasked | output | 1 | Legal write is write-per-bit masked |
| dinMask | output | 1 | Write data mask, latency 0 |
| doutHiZ | output | 1 | Read output disable, latency 2 |
| bankOpen | output | 2 | Per-bank open state |
| bankIdle | output | 2 | Per-bank idle state |
| bankWpb | output | 2 | Per-bank write-per-bit flag |

## Verification
The assertions check the following properties on every cycle:
- `cmdHot` is always one-hot.
- The graphics variant of MODE SET appears whenever the pin is high.
- A bank only opens from an ACTIVATE addressed to it, and it latches its write-per-bit flag from that edge.
- An open bank never returns to idle in one step.
- A legal refresh or burst stop is only reported under the state that permits it.
- Both byte-mask latencies hold.

The bench's scenarios show the rest. They track the precharge countdown with its exact idle edge, the auto-precharge window and the burst stop that cancels it, the rejection of accesses to closed banks, and the fact that a rejected command leaves every flag untouched.

// File: rtl/sgram_pkg.sv
package sgram_pkg;
  localparam int PAGE_LEN = 256;
  localparam int LEN_W = $clog2(PAGE_LEN + 1);
  localparam int CMD_N = 10;
  localparam int NUM_BANKS = 2;
  localparam logic [2:0] FULL_PAGE_CODE = 3'd7;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_ACT    = 4'd1,
    CMD_READ   = 4'd2,
    CMD_WRITE  = 4'd3,
    CMD_BWRITE = 4'd4,
    CMD_PRE    = 4'd5,
    CMD_REF    = 4'd6,
    CMD_MRS    = 4'd7,
    CMD_SMRS   = 4'd8,
    CMD_BSTOP  = 4'd9
  } cmdIdx_e;

  typedef enum logic [1:0] {
    BANK_IDLE  = 2'd0,
    BANK_OPEN  = 2'd1,
    BANK_PRECH = 2'd2
  } bankState_e;

  typedef struct packed {
    logic             doAct;
    logic             doAccess;
    logic             doPre;
    logic             doStop;
    logic             tgtBank;
    logic             allBanks;
    logic             wpbSet;
    logic             autoPre;
    logic [LEN_W-1:0] burstLen;
  } ctrlStrobe_t;
endpackage

// File: rtl/sgram_cmd_ctrl.sv
module sgram_cmd_ctrl
  import sgram_pkg::*;
(
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 dsf,
  input  logic                 bankSel,
  input  logic                 apAll,
  input  logic [2:0]           burstCode,
  input  logic [NUM_BANKS-1:0] bankIsIdle,
  input  logic [NUM_BANKS-1:0] bankIsOpen,
  input  logic                 burstBusyAp,
  output logic [CMD_N-1:0]     cmdHotNext,
  output logic                 violation,
  output ctrlStrobe_t          strobe
);
  cmdIdx_e          cmd;
  logic [LEN_W-1:0] seqLen;
  logic             isAccess;

  // strobe pins to command, graphics pin choosing the variant
  always_comb begin
    cmd = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = dsf ? CMD_BWRITE : CMD_WRITE;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = dsf ? CMD_SMRS : CMD_MRS;
        3'b110:  cmd = CMD_BSTOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign cmdHotNext = CMD_N'(1) << cmd;

  always_comb begin
    case (burstCode)
      3'd0:           seqLen = LEN_W'(1);
      3'd1:           seqLen = LEN_W'(2);
      3'd2:           seqLen = LEN_W'(4);
      3'd3:           seqLen = LEN_W'(8);
      FULL_PAGE_CODE: seqLen = LEN_W'(PAGE_LEN);
      default:        seqLen = LEN_W'(1);
    endcase
  end

  assign isAccess = (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_BWRITE);

  always_comb begin
    violation = 1'b0;
    case (cmd)
      CMD_ACT:   violation = !bankIsIdle[bankSel];
      CMD_REF:   violation = !(&bankIsIdle);
      CMD_BSTOP: violation = (burstCode != FULL_PAGE_CODE);
      default:   violation = isAccess && (!bankIsOpen[bankSel] || burstBusyAp);
    endcase
  end

  always_comb begin
    strobe.doAct    = (cmd == CMD_ACT) && !violation;
    strobe.doAccess = isAccess && !violation;
    strobe.doPre    = (cmd == CMD_PRE);
    strobe.doStop   = (cmd == CMD_BSTOP) && !violation;
    strobe.tgtBank  = bankSel;
    strobe.allBanks = apAll;
    strobe.wpbSet   = dsf;
    strobe.autoPre  = apAll;
    strobe.burstLen = (cmd == CMD_BWRITE) ? LEN_W'(1) : seqLen;
  end
endmodule

// File: rtl/sgram_bank_path.sv
module sgram_bank_path
  import sgram_pkg::*;
#(
  parameter int TRP    = 3,
  parameter int RD_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [CMD_N-1:0]     cmdHotNext,
  input  logic                 violation,
  input  logic                 dqm,
  output logic [CMD_N-1:0]     cmdHot,
  output logic                 cmdBank,
  output logic                 errPulse,
  output logic                 wrMasked,
  output logic                 dinMask,
  output logic                 doutHiZ,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] bankWpb,
  output logic                 burstBusyAp
);
  localparam int PRE_W = $clog2(TRP + 1);

  logic [LEN_W-1:0]    burstRem;
  logic                burstAp;
  logic                burstBank;
  logic                apDone;
  logic [RD_LAT:0]     dqmPipe;
  logic                isWriteish;

  assign burstBusyAp = (burstRem != '0) && burstAp;
  assign apDone      = !strobe.doStop && (burstRem == LEN_W'(1)) && burstAp;
  assign isWriteish  = cmdHotNext[CMD_WRITE] || cmdHotNext[CMD_BWRITE];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bankState_e       state;
    logic [PRE_W-1:0] cnt;
    logic             startPre;

    assign startPre = (state == BANK_OPEN) &&
      ((strobe.doPre && (strobe.allBanks || strobe.tgtBank == 1'(b))) ||
       (apDone && burstBank == 1'(b)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        state      <= BANK_IDLE;
        cnt        <= '0;
        bankWpb[b] <= 1'b0;
      end else if (strobe.doAct && strobe.tgtBank == 1'(b)) begin
        state      <= BANK_OPEN;
        bankWpb[b] <= strobe.wpbSet;
      end else if (startPre) begin
        state <= BANK_PRECH;
        cnt   <= PRE_W'(TRP);
      end else if (state == BANK_PRECH) begin
        if (cnt <= PRE_W'(1)) begin
          state <= BANK_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt - PRE_W'(1);
        end
      end
    end

    assign bankOpen[b] = (state == BANK_OPEN);
    assign bankIdle[b] = (state == BANK_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstRem  <= '0;
      burstAp   <= 1'b0;
      burstBank <= 1'b0;
    end else if (strobe.doAccess) begin
      burstRem  <= strobe.burstLen;
      burstAp   <= strobe.autoPre;
      burstBank <= strobe.tgtBank;
    end else if (strobe.doStop) begin
      burstRem <= '0;
      burstAp  <= 1'b0;
    end else if (burstRem != '0) begin
      burstRem <= burstRem - LEN_W'(1);
      if (burstRem == LEN_W'(1)) burstAp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdHot   <= CMD_N'(1);
      cmdBank  <= 1'b0;
      errPulse <= 1'b0;
      wrMasked <= 1'b0;
      dqmPipe  <= '0;
    end else begin
      cmdHot   <= cmdHotNext;
      cmdBank  <= strobe.tgtBank;
      errPulse <= violation;
      wrMasked <= strobe.doAccess && isWriteish && bankWpb[strobe.tgtBank];
      dqmPipe  <= {dqmPipe[RD_LAT-1:0], dqm};
    end
  end

  assign dinMask = dqmPipe[0];
  assign doutHiZ = dqmPipe[RD_LAT];
endmodule

// File: rtl/sgram_cmd_check.sv
module sgram_cmd_check
  import sgram_pkg::*;
#(
  parameter int TRP    = 3,
  parameter int RD_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 dsf,
  input  logic                 bankSel,
  input  logic                 apAll,
  input  logic [2:0]           burstCode,
  input  logic                 dqm,
  output logic [CMD_N-1:0]     cmdHot,
  output logic                 cmdBank,
  output logic                 errPulse,
  output logic                 wrMasked,
  output logic                 dinMask,
  output logic                 doutHiZ,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] bankWpb
);
  ctrlStrobe_t        strobe;
  logic [CMD_N-1:0]   cmdHotNext;
  logic               violation;
  logic               burstBusyAp;

  sgram_cmd_ctrl u_ctrl (
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .dsf        (dsf),
    .bankSel    (bankSel),
    .apAll      (apAll),
    .burstCode  (burstCode),
    .bankIsIdle (bankIdle),
    .bankIsOpen (bankOpen),
    .burstBusyAp(burstBusyAp),
    .cmdHotNext (cmdHotNext),
    .violation  (violation),
    .strobe     (strobe)
  );

  sgram_bank_path #(.TRP(TRP), .RD_LAT(RD_LAT)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdHotNext (cmdHotNext),
    .violation  (violation),
    .dqm        (dqm),
    .cmdHot     (cmdHot),
    .cmdBank    (cmdBank),
    .errPulse   (errPulse),
    .wrMasked   (wrMasked),
    .dinMask    (dinMask),
    .doutHiZ    (doutHiZ),
    .bankOpen   (bankOpen),
    .bankIdle   (bankIdle),
    .bankWpb    (bankWpb),
    .burstBusyAp(burstBusyAp)
  );
endmodule

// File: rtl/sgram_cmd_check_sva.sv
module sgram_cmd_check_sva (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       dsf,
  input logic       bankSel,
  input logic [2:0] burstCode,
  input logic       dqm,
  input logic [9:0] cmdHot,
  input logic       errPulse,
  input logic       dinMask,
  input logic       doutHiZ,
  input logic [1:0] bankOpen,
  input logic [1:0] bankIdle,
  input logic [1:0] bankWpb
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmdHot) == 1);

  p_special_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && !weN && dsf) |=> cmdHot[8]);

  p_open_from_act_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $rose(bankOpen[0])) |->
      $past(!csN && !rasN && casN && weN && !bankSel));

  p_wpb_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $rose(bankOpen[1])) |-> bankWpb[1] == $past(dsf));

  p_no_direct_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    bankOpen[0] |=> !bankIdle[0]);

  p_stop_fullpage_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && cmdHot[9] && !errPulse) |-> $past(burstCode) == 3'd7);

  p_refresh_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && cmdHot[6] && !errPulse) |-> $past(&bankIdle));

  p_din_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0) |-> dinMask == $past(dqm));

  p_dout_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> doutHiZ == $past(dqm, 3));
endmodule

bind sgram_cmd_check sgram_cmd_check_sva u_sva (.*);

// File: tb/sgram_cmd_check_tb_top.sv
`timescale 1ns/1ps
module sgram_cmd_check_tb_top;
  localparam int TRP = 3;
  localparam int PAGE = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic dsf = 1'b0, bankSel = 1'b0, apAll = 1'b0, dqm = 1'b0;
  logic [2:0] burstCode = 3'd1;
  logic [9:0] cmdHot;
  logic cmdBank, errPulse, wrMasked, dinMask, doutHiZ;
  logic [1:0] bankOpen, bankIdle, bankWpb;

  int checks = 0, fails = 0;
  bit chkOn = 1'b0;

  always #5 clk = ~clk;

  sgram_cmd_check #(.TRP(TRP)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .dsf(dsf), .bankSel(bankSel), .apAll(apAll), .burstCode(burstCode), .dqm(dqm),
    .cmdHot(cmdHot), .cmdBank(cmdBank), .errPulse(errPulse), .wrMasked(wrMasked),
    .dinMask(dinMask), .doutHiZ(doutHiZ), .bankOpen(bankOpen), .bankIdle(bankIdle),
    .bankWpb(bankWpb)
  );

  // ---------------- behavioural reference model ----------------
  int  mState[2];   // 0 idle, 1 open, 2 precharging
  int  mCnt[2];
  int  mWpb[2];
  int  mRem, mAp, mBank;
  bit  mDq[$];
  int  eCmd, eBank, eErr, eWrM, eDin, eHiZ;

  function automatic int burstOf(input logic [2:0] code, input int blk);
    if (blk != 0) return 1;
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return PAGE;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    int c, bad, acc, apFin, sel;
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin mState[b] = 0; mCnt[b] = 0; mWpb[b] = 0; end
      mRem = 0; mAp = 0; mBank = 0; mDq.delete();
      eCmd = 0; eBank = 0; eErr = 0; eWrM = 0; eDin = 0; eHiZ = 0;
    end else begin
      sel = int'(bankSel);
      c = 0;
      if (!csN) begin
        if (!rasN && casN && weN) c = 1;
        else if (rasN && !casN && weN) c = 2;
        else if (rasN && !casN && !weN) c = dsf ? 4 : 3;
        else if (!rasN && casN && !weN) c = 5;
        else if (!rasN && !casN && weN) c = 6;
        else if (!rasN && !casN && !weN) c = dsf ? 8 : 7;
        else if (rasN && casN && !weN) c = 9;
      end
      acc = (c == 2 || c == 3 || c == 4) ? 1 : 0;
      bad = 0;
      if (c == 1 && mState[sel] != 0) bad = 1;
      if (acc != 0 && (mState[sel] != 1 || (mRem > 0 && mAp != 0))) bad = 1;
      if (c == 6 && (mState[0] != 0 || mState[1] != 0)) bad = 1;
      if (c == 9 && burstCode != 3'd7) bad = 1;
      eCmd = c; eBank = sel; eErr = bad;
      eWrM = (acc != 0 && bad == 0 && c != 2 && mWpb[sel] != 0) ? 1 : 0;
      apFin = (!(c == 9 && bad == 0) && mRem == 1 && mAp != 0) ? 1 : 0;
      for (int b = 0; b < 2; b++) begin
        if (c == 1 && bad == 0 && sel == b) begin
          mState[b] = 1; mWpb[b] = int'(dsf);
        end else if (mState[b] == 1 &&
                     ((c == 5 && (apAll || sel == b)) || (apFin != 0 && mBank == b))) begin
          mState[b] = 2; mCnt[b] = TRP;
        end else if (mState[b] == 2) begin
          if (mCnt[b] <= 1) begin mState[b] = 0; mCnt[b] = 0; end
          else mCnt[b] = mCnt[b] - 1;
        end
      end
      if (acc != 0 && bad == 0) begin
        mRem = burstOf(burstCode, c == 4 ? 1 : 0); mAp = int'(apAll); mBank = sel;
      end else if (c == 9 && bad == 0) begin
        mRem = 0; mAp = 0;
      end else if (mRem > 0) begin
        mRem = mRem - 1;
        if (mRem == 0) mAp = 0;
      end
      mDq.push_back(dqm);
      if (mDq.size() > 3) void'(mDq.pop_front());
      eDin = int'(dqm);
      eHiZ = (mDq.size() == 3) ? int'(mDq[0]) : 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      chk(int'(cmdHot), 1 << eCmd, "R1 R2 cmdHot");
      chk(int'(cmdBank), eBank, "R3 cmdBank");
      chk(int'(errPulse), eErr, "R6 R7 R8 R9 R10 errPulse");
      chk(int'(wrMasked), eWrM, "R4 wrMasked");
      chk(int'(dinMask), eDin, "R11 dinMask");
      chk(int'(doutHiZ), eHiZ, "R11 doutHiZ");
      for (int b = 0; b < 2; b++) begin
        chk(int'(bankOpen[b]), mState[b] == 1 ? 1 : 0, "R3 R5 bankOpen");
        chk(int'(bankIdle[b]), mState[b] == 0 ? 1 : 0, "R5 R7 bankIdle");
        chk(int'(bankWpb[b]), mWpb[b], "R4 R10 bankWpb");
      end
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         REF = 3'b001, MRS = 3'b000, STOP = 3'b110;

  task automatic issue(input logic [2:0] rcw, input logic d, input logic sel, input logic a8);
    csN = 1'b0; {rasN, casN, weN} = rcw; dsf = d; bankSel = sel; apAll = a8;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    csN = 1'b1; {rasN, casN, weN} = 3'b111; dsf = 1'b0; apAll = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(int'(cmdHot), 1, "R12 cmdHot reset");
    chk(int'(bankIdle), 3, "R12 bankIdle reset");
    chk(int'(bankOpen | bankWpb), 0, "R12 open/wpb reset");
    chk(int'({errPulse, wrMasked, dinMask, doutHiZ}), 0, "R12 strobes reset");
    rstN = 1'b1;
    chkOn = 1'b1;
    idle(1);

    issue(MRS, 1'b0, 1'b0, 1'b0); chk(int'(cmdHot), 1 << 7, "R1 mode set");
    issue(MRS, 1'b1, 1'b0, 1'b0); chk(int'(cmdHot), 1 << 8, "R2 special mode set");
    issue(REF, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 0, "R9 refresh both idle");
    issue(ACT, 1'b1, 1'b0, 1'b0); chk(int'(bankWpb[0]), 1, "R4 wpb on at activate");
    issue(ACT, 1'b0, 1'b1, 1'b0); chk(int'(bankOpen), 3, "R3 both open");
    issue(ACT, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 1, "R3 activate open bank");
    chk(int'(bankWpb[0]), 1, "R10 wpb unchanged by bad activate");
    idle(1);                      chk(int'(errPulse), 0, "R10 error lasts one cycle");
    issue(REF, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 1, "R9 refresh with open banks");
    issue(WR, 1'b0, 1'b0, 1'b0);  chk(int'(wrMasked), 1, "R4 masked write bank A");
    idle(2);
    issue(WR, 1'b0, 1'b1, 1'b0);  chk(int'(wrMasked), 0, "R4 unmasked write bank B");
    chk(int'(cmdBank), 1, "R3 bank B reported");
    idle(2);
    issue(WR, 1'b1, 1'b0, 1'b0);  chk(int'(cmdHot), 1 << 4, "R2 block write");
    issue(STOP, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 1, "R8 stop outside full page");

    dqm = 1'b1;
    issue(RD, 1'b0, 1'b0, 1'b0);  chk(int'(dinMask), 1, "R11 write mask latency 0");
    chk(int'(doutHiZ), 0, "R11 hi-z not yet");
    dqm = 1'b0;
    idle(1);                      chk(int'(doutHiZ), 0, "R11 hi-z after one edge");
    idle(1);                      chk(int'(doutHiZ), 1, "R11 hi-z after two edges");
    idle(4);

    burstCode = 3'd7;
    issue(RD, 1'b0, 1'b1, 1'b0);
    issue(STOP, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 0, "R8 stop in full page");
    idle(1);

    burstCode = 3'd2;
    issue(RD, 1'b0, 1'b0, 1'b1);
    issue(WR, 1'b0, 1'b1, 1'b0);  chk(int'(errPulse), 1, "R7 access during auto-precharge burst");
    idle(3);                      chk(int'({bankOpen[0], bankIdle[0]}), 0, "R7 bank A precharging");
    issue(ACT, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 1, "R5 activate while precharging");
    idle(3);                      chk(int'(bankIdle[0]), 1, "R5 idle after TRP");
    issue(RD, 1'b0, 1'b0, 1'b0);  chk(int'(errPulse), 1, "R6 read to idle bank");
    issue(WR, 1'b0, 1'b1, 1'b0);  chk(int'(errPulse), 0, "R6 write to open bank B");
    idle(4);
    issue(PRE, 1'b0, 1'b0, 1'b1); chk(int'(bankOpen), 0, "R5 precharge all banks");
    idle(TRP);
    issue(REF, 1'b0, 1'b0, 1'b0); chk(int'(errPulse), 0, "R9 refresh after precharge");

    csN = 1'b1; rasN = 1'b0; casN = 1'b0; weN = 1'b0;
    @(negedge clk);               chk(int'(cmdHot), 1, "R1 deselect is NOP");
    idle(3);
    chkOn = 1'b0;
    summary();
  end
endmodule